// File: doc/BRIEF.md
# I2C Slave Control Register Port

This block is the serial control port of a small signal-routing controller. It watches the two-wire bus lines, SCL and SDA, through synchronizers clocked by the system clock. From these it detects START and STOP conditions and clocks bytes in and out. When the master addresses it, it acknowledges by pulling SDA low through an open-drain enable. A strap input chooses which of two fixed 7-bit addresses the port answers to, so two such controllers can share a bus.

A write stores successive data bytes into a bank of four 8-bit control registers. There is no pointer byte: the first data byte after the address always goes to register 0, the next to register 1, and so on. A read returns one status byte. Its upper nibble is a constant chip identifier, and its lower nibble is a status vector captured when the read address is acknowledged. A general-call address followed by the reset code returns every control register to its power-up value.

Top module: `i2c_regport`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state, including a repeated START in the middle of a transfer, and leaves `sda_pull` low. A STOP is SDA rising while SCL is high.
- R2: Bits are taken MSB first, on SCL rising. The 7-bit address is 1001000 (0x48) when `addr_sel` is 1 and 1010000 (0x50) when it is 0. Bit 0 of the address byte is the direction: 0 for write, 1 for read. On a match, `sda_pull` goes high on the SCL fall that ends the eighth bit, holds through the ninth clock pulse, and is released on the fall that ends it.
- R3: If the address does not match, SDA is never pulled, and all following bytes are ignored until the next START.
- R4: In a write, data bytes go to register 0, then 1, then 2, then 3, and each data byte is acknowledged. Register k appears on `regs_out[8k+7:8k]`. The register index returns to 0 at every START.
- R5: Data bytes after the fourth in one write are acknowledged and discarded.
- R6: A read shifts out 8 bits MSB first, changing SDA only on SCL falling edges. Bits 7:4 are 0010. Bits 3:0 are `status_in` as sampled at the address acknowledge; later changes to `status_in` do not alter the byte.
- R7: After the master's acknowledge bit that follows the read byte, SDA stays released until the next START.
- R8: The address byte 0x00 (general call) is acknowledged. A following data byte of 0x06 restores all registers to their defaults. Any other general-call data byte leaves the registers unchanged.
- R9: Asserting `rst_n` low loads the default register values (0x81, 0x3C, 0x00, 0x5A for registers 0 to 3) and releases SDA.
- R10: A STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 1 | Address strap: 1 selects 0x48, 0 selects 0x50 |
| status_in | input | 4 | Status bits returned in the low nibble of a read |
| regs_out | output | 32 | Control registers; register k occupies bits 8k+7:8k |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
A corrupted register index or shift count shows up at `regs_out`. It appears within a few system clocks of the SCL fall that ends the affected data byte, as a byte in the wrong register or a wrong value. A wrong engine state, such as missing a mismatch or leaving a drive on after a read, shows up as `sda_pull` asserted in a bit period where the bus should stay high. The master samples this in the next SCL high phase. The reference model compares all four registers on every system clock, except for a short window after each byte-ending fall. Acknowledge and read bits are compared at each SCL high.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_WDATA,
    LK_WACK,
    LK_RDATA,
    LK_RACK,
    LK_SKIP
  } link_state_t;

  // Address byte decode: own address with either direction, or a general call write.
  function automatic logic addr_match(input logic [7:0] abyte, input logic sel,
                                      input logic [6:0] addr_hi, input logic [6:0] addr_lo);
    logic [6:0] own;
    own = sel ? addr_hi : addr_lo;
    return (abyte[7:1] == own) || (abyte == 8'h00);
  endfunction

  function automatic logic is_general_call(input logic [7:0] abyte);
    return abyte == 8'h00;
  endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_in};
      sda_chain <= {sda_chain[STAGES-2:0], sda_in};
      scl_d     <= scl_s;
      sda_d     <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import i2c_regport_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter int         REG_W    = 8,
  parameter int         ID_W     = 4,
  parameter logic [3:0] CHIP_ID  = 4'b0010,
  parameter logic [6:0] ADDR_HI  = 7'h48,
  parameter logic [6:0] ADDR_LO  = 7'h50,
  localparam int STAT_W = REG_W - ID_W,
  localparam int IDX_W  = $clog2(NUM_REGS + 1),
  localparam int WIX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int CNT_W  = $clog2(REG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_sel,
  input  logic [STAT_W-1:0] status_in,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [WIX_W-1:0]  wr_idx,
  output logic [REG_W-1:0]  wr_data,
  output logic              soft_rst
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(REG_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS);

  link_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [REG_W-1:0]  shreg;
  logic [IDX_W-1:0]  idx;
  logic [STAT_W-1:0] stat_q;
  logic              rw, gc;

  function automatic logic [REG_W-1:0] read_word(input logic [STAT_W-1:0] st);
    return {CHIP_ID[ID_W-1:0], st};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LK_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      idx      <= '0;
      stat_q   <= '0;
      rw       <= 1'b0;
      gc       <= 1'b0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      soft_rst <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      soft_rst <= 1'b0;
      if (start_evt) begin
        state    <= LK_ADDR;
        cnt      <= '0;
        idx      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state    <= LK_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          LK_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[REG_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (addr_match(shreg, addr_sel, ADDR_HI, ADDR_LO)) begin
                sda_pull <= 1'b1;
                rw       <= shreg[0];
                gc       <= is_general_call(shreg);
                stat_q   <= status_in;
                state    <= LK_AACK;
              end else begin
                state <= LK_SKIP;
              end
            end
          end
          LK_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                sda_pull <= ~read_word(stat_q)[REG_W-1];
                shreg    <= {read_word(stat_q)[REG_W-2:0], 1'b0};
                cnt      <= CNT_W'(1);
                state    <= LK_RDATA;
              end else begin
                sda_pull <= 1'b0;
                cnt      <= '0;
                state    <= LK_WDATA;
              end
            end
          end
          LK_WDATA: begin
            if (scl_rise) begin
              shreg <= {shreg[REG_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              sda_pull <= 1'b1;
              state    <= LK_WACK;
              if (gc) begin
                soft_rst <= (shreg == REG_W'(6));
              end else begin
                if (idx < LAST) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= WIX_W'(idx);
                  wr_data <= shreg;
                  idx     <= idx + 1'b1;
                end
              end
            end
          end
          LK_WACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= LK_WDATA;
            end
          end
          LK_RDATA: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_pull <= 1'b0;
                state    <= LK_RACK;
              end else begin
                sda_pull <= ~shreg[REG_W-1];
                shreg    <= {shreg[REG_W-2:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          LK_RACK: begin
            if (scl_fall) state <= LK_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int                      NUM_REGS  = 4,
  parameter int                      REG_W     = 8,
  parameter logic [NUM_REGS*REG_W-1:0] RESET_VAL = 32'h5A00_3C81,
  localparam int WIX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WIX_W-1:0]          wr_idx,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      soft_rst,
  output logic [NUM_REGS*REG_W-1:0] regs_out
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= RESET_VAL[k*REG_W +: REG_W];
      else if (soft_rst)                         q <= RESET_VAL[k*REG_W +: REG_W];
      else if (wr_en && wr_idx == WIX_W'(k))     q <= wr_data;
    end
    assign regs_out[k*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int                        NUM_REGS  = 4,
  parameter int                        REG_W     = 8,
  parameter int                        ID_W      = 4,
  parameter logic [3:0]                CHIP_ID   = 4'b0010,
  parameter logic [6:0]                ADDR_HI   = 7'h48,
  parameter logic [6:0]                ADDR_LO   = 7'h50,
  parameter int                        SYNC_LEN  = 2,
  parameter logic [NUM_REGS*REG_W-1:0] RESET_VAL = 32'h5A00_3C81,
  localparam int STAT_W = REG_W - ID_W,
  localparam int WIX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_in,
  input  logic                      sda_in,
  input  logic                      addr_sel,
  input  logic [STAT_W-1:0]         status_in,
  output logic [NUM_REGS*REG_W-1:0] regs_out,
  output logic                      sda_pull
);
  logic             sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en, soft_rst;
  logic [WIX_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;

  i2c_line_sense #(.STAGES(SYNC_LEN)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_link_fsm #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W), .CHIP_ID(CHIP_ID),
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_sel(addr_sel), .status_in(status_in), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .soft_rst(soft_rst)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .soft_rst(soft_rst), .regs_out(regs_out)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int                        NUM_REGS  = 4,
  parameter int                        REG_W     = 8,
  parameter logic [NUM_REGS*REG_W-1:0] RESET_VAL = 32'h5A00_3C81
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scl_fall,
  input logic                      start_evt,
  input logic                      stop_evt,
  input logic                      wr_en,
  input logic                      soft_rst,
  input logic                      sda_pull,
  input logic [NUM_REGS*REG_W-1:0] regs_out
);
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  a_r6_drive_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  a_r4_write_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall));

  a_r8_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs_out == RESET_VAL));

  a_r4_regs_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !soft_rst) |=> $stable(regs_out));
endmodule

bind i2c_regport i2c_regport_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .wr_en(wr_en), .soft_rst(soft_rst),
  .sda_pull(sda_pull), .regs_out(regs_out)
);

// File: tb/test_i2c_regport.sv
`timescale 1ns/1ps
module test_i2c_regport;
  localparam int Q = 8;
  localparam logic [31:0] DFLT = {8'h5A, 8'h00, 8'h3C, 8'h81};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
  logic [3:0] status_in = 4'h0;
  logic [31:0] regs_out;
  logic sda_pull;
  wire sda_bus = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regport i_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_sel(addr_sel), .status_in(status_in), .regs_out(regs_out), .sda_pull(sda_pull)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0, cmp_en = 1'b0;
  logic [7:0] exp_regs [4];
  logic [7:0] exp_nx [4];
  int m_idx = 0;
  bit m_hit = 1'b0, m_gc = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec();
    return {exp_regs[3], exp_regs[2], exp_regs[1], exp_regs[0]};
  endfunction

  task automatic load_defaults(output logic [7:0] r [4]);
    for (int i = 0; i < 4; i++) r[i] = DFLT[i*8 +: 8];
  endtask

  // model compared every clock (R4 R5 R8 R9)
  always @(negedge clk) if (cmp_en && rst_n) chk("R4 regs model", regs_out, exp_vec());

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, input bit last, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_bus; tick(Q);
    if (last) cmp_en = 1'b0;
    scl_m = 1'b0; tick(Q);
    if (last) begin exp_regs = exp_nx; cmp_en = 1'b1; end
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic ackd);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], i == 0, r);
    bit_x(1'b1, 1'b0, r);
    ackd = ~r;
  endtask

  task automatic do_start();
    exp_nx = exp_regs; m_idx = 0;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
    chk("R10 released after stop", {31'b0, sda_pull}, 32'h0);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, input bit want, input string req);
    logic ack;
    exp_nx = exp_regs;
    xfer_byte({a, rw}, ack);
    chk(req, {31'b0, ack}, {31'b0, want});
    m_hit = want && !rw;
    m_gc  = want && ({a, rw} == 8'h00);
  endtask

  task automatic send_data(input logic [7:0] b, input string req);
    logic ack;
    exp_nx = exp_regs;
    if (m_gc) begin
      if (b == 8'h06) load_defaults(exp_nx);
    end else if (m_hit) begin
      if (m_idx < 4) exp_nx[m_idx] = b;
      m_idx++;
    end
    xfer_byte(b, ack);
    chk(req, {31'b0, ack}, {31'b0, m_hit});
  endtask

  task automatic read_byte(input bit master_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, 1'b0, r); v[i] = r; end
    bit_x(master_ack ? 1'b0 : 1'b1, 1'b0, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic r;
    load_defaults(exp_regs);
    exp_nx = exp_regs;
    tick(3);
    // R9: reset state
    chk("R9 reset regs", regs_out, DFLT);
    chk("R9 reset sda released", {31'b0, sda_pull}, 32'h0);
    rst_n = 1'b1; tick(4);
    cmp_en = 1'b1;

    // R2 R4: two-byte write at 0x48
    do_start();
    send_addr(7'h48, 1'b0, 1'b1, "R2 ack at 0x48 strap high");
    send_data(8'h11, "R4 data ack");
    send_data(8'h22, "R4 data ack");
    do_stop();
    chk("R4 reg0 reg1 written", regs_out, {8'h5A, 8'h00, 8'h22, 8'h11});

    // R5: six bytes, last two discarded
    do_start();
    send_addr(7'h48, 1'b0, 1'b1, "R2 ack");
    for (int i = 0; i < 6; i++) send_data(8'hA0 + 8'(i), "R5 every byte acked");
    do_stop();
    chk("R5 extra bytes discarded", regs_out, 32'hA3A2A1A0);

    // R3: wrong address ignored
    do_start();
    send_addr(7'h50, 1'b0, 1'b0, "R3 no ack on mismatch");
    send_data(8'hFF, "R3 data not acked");
    do_stop();
    chk("R3 regs unchanged", regs_out, 32'hA3A2A1A0);

    // R2: strap low selects 0x50
    addr_sel = 1'b0;
    do_start();
    send_addr(7'h48, 1'b0, 1'b0, "R3 old address ignored");
    do_start();
    send_addr(7'h50, 1'b0, 1'b1, "R2 ack at 0x50 strap low");
    send_data(8'h77, "R4 data ack");
    do_stop();
    chk("R2 write at 0x50", regs_out, 32'hA3A2A177);

    // R1 R4: repeated start restarts at register 0
    do_start();
    send_addr(7'h50, 1'b0, 1'b1, "R1 ack");
    send_data(8'h01, "R4 data ack");
    send_data(8'h02, "R4 data ack");
    do_start();
    send_addr(7'h50, 1'b0, 1'b1, "R1 ack after repeated start");
    send_data(8'h09, "R4 data ack");
    do_stop();
    chk("R1 index restart", regs_out, 32'hA3A20209);

    // R6 R7: read, status changed after acknowledge
    status_in = 4'hB;
    do_start();
    send_addr(7'h50, 1'b1, 1'b1, "R6 read address ack");
    status_in = 4'h4;
    read_byte(1'b1, v);
    chk("R6 read word id+latched status", {24'b0, v}, 32'h2B);
    bit_x(1'b1, 1'b0, r);
    chk("R7 released after master ack", {31'b0, r}, 32'h1);
    bit_x(1'b1, 1'b0, r);
    chk("R7 still released", {31'b0, r}, 32'h1);
    do_stop();

    // R6: second read with new status, master NACK
    do_start();
    send_addr(7'h50, 1'b1, 1'b1, "R6 read address ack");
    read_byte(1'b0, v);
    chk("R6 read word second", {24'b0, v}, 32'h24);
    do_stop();

    // R8: general call, other code no effect, then reset code
    do_start();
    send_addr(7'h00, 1'b0, 1'b1, "R8 general call acked");
    send_data(8'h05, "R8 data ack");
    do_stop();
    chk("R8 other code no effect", regs_out, 32'hA3A20209);
    do_start();
    send_addr(7'h00, 1'b0, 1'b1, "R8 general call acked");
    send_data(8'h06, "R8 data ack");
    do_stop();
    chk("R8 soft reset to defaults", regs_out, DFLT);

    // R9: asynchronous reset after a write
    do_start();
    send_addr(7'h50, 1'b0, 1'b1, "R2 ack");
    send_data(8'hEE, "R4 data ack");
    do_stop();
    chk("R4 written before reset", regs_out, {8'h5A, 8'h00, 8'h3C, 8'hEE});
    cmp_en = 1'b0;
    rst_n = 1'b0; tick(2);
    chk("R9 async reset regs", regs_out, DFLT);
    chk("R9 async reset sda", {31'b0, sda_pull}, 32'h0);
    load_defaults(exp_regs);
    rst_n = 1'b1; tick(2);
    cmp_en = 1'b1; tick(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule